// File: doc/BRIEF.md
# Card Configuration and Mode Selector

This block sits behind the host pins of a removable flash card. It fixes two things for the whole power cycle, the interface personality and the drive role. The personality is either PC-card ATA or True-IDE, and the drive role is master or slave. It then hosts the byte-wide configuration registers in attribute memory. The host writes a 6-bit index into the option register, and the block turns that index into the active task-register mapping. The mapping is one of memory-mapped, contiguous I/O, primary I/O or secondary I/O.

Strap capture uses a capture flag. The flag is set asynchronously while `rst_ni` is low and is cleared by the first clock after release. While the flag is set, each rising clock edge loads the strap pins. The last value loaded is the level at the release edge. The clock must run during reset. The host strobes are active-low levels sampled on the block clock. A write takes effect on each rising edge where `we_ni` is low. Read data is combinational while `oe_ni` is low.

Top module: `cfg_mode_sel`

## Requirements
- R1: After reset, `map_mode_o` is 0 (memory-mapped). All four configuration registers read back 00H.
- R2: When `ata_sel_i` is high at the end of reset, the PC-card ATA personality is selected and `ide_mode_o` = 0. When it is low, True-IDE is selected and `ide_mode_o` = 1.
- R3: When `drv_sel_ni` is low at the end of reset, the card is master and `slave_o` = 0. When it is high (the pulled-up open state), the card is slave and `slave_o` = 1.
- R4: Once reset has ended, `ide_mode_o` and `slave_o` ignore any change on `ata_sel_i` and `drv_sel_ni`. Only a new reset changes them.
- R5: In PC-card ATA personality with `reg_ni` low, the addresses 200H, 202H, 204H and 206H each hold a full 8-bit register. These are the option, status, pin-replacement and socket-copy registers. A write is visible on `rdata_o` from the next cycle onward.
- R6: Accesses with `reg_ni` high (common memory) do not touch the configuration registers. Reads of them return 00H.
- R7: Odd attribute addresses, and attribute addresses outside 200H–207H, read 00H and ignore writes.
- R8: Writing the option register with bits 5:0 equal to 0, 1, 2 or 3 sets `map_mode_o` to 0 (memory), 1 (contiguous I/O), 2 (primary I/O) or 3 (secondary I/O) from the next cycle.
- R9: An option-register write with bits 5:0 of 4 or more stores the byte but leaves `map_mode_o` unchanged.
- R10: In True-IDE personality the configuration registers are invisible. Reads return 00H, writes are ignored and `map_mode_o` stays 0.
- R11: `rdata_o` is 00H whenever `oe_ni` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ata_sel_i | input | 1 | Personality strap, high = PC-card ATA |
| drv_sel_ni | input | 1 | Drive strap, low = master, high = slave |
| reg_ni | input | 1 | Low selects attribute memory |
| oe_ni | input | 1 | Active-low read strobe |
| we_ni | input | 1 | Active-low write strobe |
| addr_i | input | 11 | Host address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 00H when not a register read |
| ide_mode_o | output | 1 | 1 = True-IDE personality |
| slave_o | output | 1 | 1 = slave drive |
| map_mode_o | output | 2 | 0 memory, 1 contiguous, 2 primary, 3 secondary |

## Verification
The assertions assume the strap pins are steady at the release edge of reset. They also assume the strobes and address are driven synchronously to the block clock. The bench holds the straps until two cycles after release and only then toggles them. All host signals change on the falling clock edge. The random traffic mixes attribute and common accesses, even and odd addresses, addresses inside and outside the window, and index values above 3. Each access is a single strobe of one cycle, so every write counts exactly once.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [1:0] {
    MAP_MEM    = 2'd0,
    MAP_CONTIG = 2'd1,
    MAP_PRIM   = 2'd2,
    MAP_SEC    = 2'd3
  } map_mode_e;

  localparam int unsigned IDX_FIELD_W = 6;
endpackage

// File: rtl/cfg_strap_latch.sv
module cfg_strap_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ata_sel_i,
  input  logic drv_sel_ni,
  output logic ide_o,
  output logic slave_o
);
  logic cap_q;
  logic ide_q, slave_q;

  // capture window: set by reset, closed by first clock after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b1;
    else         cap_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (cap_q) begin
      ide_q   <= ~ata_sel_i;
      slave_q <= drv_sel_ni;
    end
  end

  assign ide_o   = ide_q;
  assign slave_o = slave_q;

  AST_STRAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_q |=> ($stable(ide_q) && $stable(slave_q))); // R4
endmodule

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec #(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned NUM_REGS = 4,
  parameter logic [ADDR_W-1:0] BASE = 11'h200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pcata_i,
  input  logic              reg_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_REGS-1:0] wr_sel_o,
  output logic [NUM_REGS-1:0] rd_sel_o
);
  localparam int unsigned SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int unsigned TOP_LSB = SEL_W + 1;

  logic hit;
  logic [SEL_W-1:0] idx;

  assign idx = addr_i[SEL_W:1];
  assign hit = pcata_i && !reg_ni && !addr_i[0]
            && (addr_i[ADDR_W-1:TOP_LSB] == BASE[ADDR_W-1:TOP_LSB]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_sel_o[g] = hit && !we_ni && (idx == SEL_W'(g));
    assign rd_sel_o[g] = hit && !oe_ni && (idx == SEL_W'(g));
  end

  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_o)); // R5
  AST_COMMON_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_ni |-> (wr_sel_o == '0 && rd_sel_o == '0)); // R6
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] wr_sel_i,
  input  logic [NUM_REGS-1:0] rd_sel_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [DATA_W-1:0]   opt_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        regs_q[g] <= '0;
      else if (wr_sel_i[g]) regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_sel_i[i]) rdata_o = rdata_o | regs_q[i];
  end

  assign opt_o = regs_q[0];

  AST_NO_RD_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == '0) |-> (rdata_o == '0)); // R11
  AST_WRITE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel_i[0] |=> (opt_o == $past(wdata_i))); // R5
endmodule

// File: rtl/cfg_mode_sel.sv
module cfg_mode_sel #(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 4,
  parameter logic [ADDR_W-1:0] BASE = 11'h200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ata_sel_i,
  input  logic              drv_sel_ni,
  input  logic              reg_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ide_mode_o,
  output logic              slave_o,
  output logic [1:0]        map_mode_o
);
  import cfg_pkg::*;

  localparam int unsigned MODE_CNT = 4;

  logic ide;
  logic [NUM_REGS-1:0] wr_sel, rd_sel;
  logic [DATA_W-1:0] opt;
  map_mode_e map_q;
  logic [IDX_FIELD_W-1:0] new_idx;

  cfg_strap_latch u_strap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ata_sel_i  (ata_sel_i),
    .drv_sel_ni (drv_sel_ni),
    .ide_o      (ide),
    .slave_o    (slave_o)
  );

  cfg_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BASE(BASE)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pcata_i  (!ide),
    .reg_ni   (reg_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .addr_i   (addr_i),
    .wr_sel_o (wr_sel),
    .rd_sel_o (rd_sel)
  );

  cfg_reg_file #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (wr_sel),
    .rd_sel_i (rd_sel),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .opt_o    (opt)
  );

  assign new_idx = wdata_i[IDX_FIELD_W-1:0];

  // mapping follows the index only for defined entries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_q <= MAP_MEM;
    else if (wr_sel[0] && (new_idx < IDX_FIELD_W'(MODE_CNT)))
      map_q <= map_mode_e'(new_idx[1:0]);
  end

  assign ide_mode_o = ide;
  assign map_mode_o = map_q;

  AST_MODE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel[0] && wdata_i[5:2] == 4'd0) |=> (map_mode_o == $past(wdata_i[1:0]))); // R8
  AST_MODE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_sel[0] || wdata_i[5:2] != 4'd0) |=> $stable(map_mode_o)); // R9
  AST_IDE_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ide_mode_o |-> (rdata_o == '0 && map_mode_o == 2'd0)); // R10
  AST_OPT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_mode_o != 2'd0) |-> (opt[5:0] >= 6'd1 || wr_sel[0] == 1'b0)); // R8
endmodule

// File: tb/cfg_mode_sel_tb.sv
module cfg_mode_sel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ata_sel = 1'b1, drv_sel_n = 1'b0;
  logic reg_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic ide, slave;
  logic [1:0] mmode;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_reg [4];
  logic [1:0] exp_mode;
  logic exp_ide;

  always #5 clk = ~clk;

  cfg_mode_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ata_sel_i(ata_sel), .drv_sel_ni(drv_sel_n),
    .reg_ni(reg_n), .oe_ni(oe_n), .we_ni(we_n), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ide_mode_o(ide), .slave_o(slave),
    .map_mode_o(mmode)
  );

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int cfg_slot(input logic [10:0] a, input logic rn, input logic is_ide);
    if (is_ide || rn || a[0] || a[10:3] != 8'h40) return -1;
    return int'(a[2:1]);
  endfunction

  task automatic do_reset(input logic ata, input logic drv);
    @(negedge clk);
    rst_n = 1'b0; ata_sel = ata; drv_sel_n = drv;
    reg_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) exp_reg[i] = 8'h00;
    exp_mode = 2'd0;
    exp_ide = ~ata;
  endtask

  task automatic do_write(input logic [10:0] a, input logic rn, input logic [7:0] d);
    int s;
    addr = a; reg_n = rn; wdata = d; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; reg_n = 1'b1;
    s = cfg_slot(a, rn, exp_ide);
    if (s >= 0) begin
      exp_reg[s] = d;
      if (s == 0 && d[5:0] < 6'd4) exp_mode = d[1:0];
    end
  endtask

  task automatic do_read(input logic [10:0] a, input logic rn, input string req);
    int s;
    addr = a; reg_n = rn; oe_n = 1'b0;
    #1;
    s = cfg_slot(a, rn, exp_ide);
    check(req, rdata, (s >= 0) ? exp_reg[s] : 8'h00);
    @(negedge clk);
    oe_n = 1'b1; reg_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    // PC-card ATA, slave
    do_reset(1'b1, 1'b1);
    check("R2", {7'd0, ide}, 8'h00);
    check("R3", {7'd0, slave}, 8'h01);
    check("R1", {6'd0, mmode}, 8'h00);
    for (int i = 0; i < 4; i++) do_read(11'h200 + 11'(2*i), 1'b0, "R1");
    // R4: toggle straps after reset
    ata_sel = 1'b0; drv_sel_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R4", {6'd0, ide, slave}, 8'h01);
    // R5 registers full byte
    for (int i = 0; i < 4; i++) do_write(11'h200 + 11'(2*i), 1'b0, 8'hA5 ^ 8'(i*8'h33) | 8'hC0);
    for (int i = 0; i < 4; i++) do_read(11'h200 + 11'(2*i), 1'b0, "R5");
    // R8 each index
    for (int m = 0; m < 4; m++) begin
      do_write(11'h200, 1'b0, 8'h40 | 8'(3 - m));
      check("R8", {6'd0, mmode}, {6'd0, exp_mode});
    end
    // R9 index >= 4 keeps mode
    do_write(11'h200, 1'b0, 8'h02);
    do_write(11'h200, 1'b0, 8'h3F);
    check("R9", {6'd0, mmode}, 8'h02);
    do_read(11'h200, 1'b0, "R9");
    do_write(11'h200, 1'b0, 8'h04);
    check("R9", {6'd0, mmode}, 8'h02);
    // R6 common memory ignored
    do_write(11'h202, 1'b1, 8'h11);
    do_read(11'h202, 1'b1, "R6");
    do_read(11'h202, 1'b0, "R6");
    // R7 odd and out of window
    do_write(11'h201, 1'b0, 8'h77);
    do_read(11'h201, 1'b0, "R7");
    do_write(11'h208, 1'b0, 8'h66);
    do_read(11'h208, 1'b0, "R7");
    do_write(11'h600, 1'b0, 8'h55);
    do_read(11'h600, 1'b0, "R7");
    do_read(11'h200, 1'b0, "R7");
    // R11 no read strobe
    addr = 11'h204; reg_n = 1'b0; #1;
    check("R11", rdata, 8'h00);
    reg_n = 1'b1;
    @(negedge clk);
    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [10:0] a;
      logic rn;
      case ($urandom_range(0, 3))
        0: a = 11'h200 + 11'($urandom_range(0, 7));
        1: a = 11'h200 + 11'(2 * $urandom_range(0, 3));
        default: a = 11'($urandom);
      endcase
      rn = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 1) == 1) do_write(a, rn, 8'($urandom));
      else do_read(a, rn, "R5");
      check("R8", {6'd0, mmode}, {6'd0, exp_mode});
    end
    // True-IDE, master
    do_reset(1'b0, 1'b0);
    check("R2", {7'd0, ide}, 8'h01);
    check("R3", {7'd0, slave}, 8'h00);
    do_write(11'h200, 1'b0, 8'h03);
    check("R10", {6'd0, mmode}, 8'h00);
    do_read(11'h200, 1'b0, "R10");
    do_read(11'h206, 1'b0, "R10");
    ata_sel = 1'b1; drv_sel_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R4", {6'd0, ide, slave}, 8'h02);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule